// File: doc/BRIEF.md
# Divided System Clock Enable with Startup Hold-Off

This block derives a system clock enable from a master clock. It divides the master clock by a programmable ratio and holds the resulting enable off until a programmable startup interval has passed. The enable is a one-cycle qualifier pulse in the master clock domain. No new clock is generated, so logic downstream keeps running on the master clock and advances only on cycles where the enable is high.

A single 16-bit control word is written by the host. Each write reloads the divide ratio and the startup exponent and restarts the startup count from zero. The startup count advances once per divider pulse. When it reaches 2^N divider pulses, the system clock is released. If the done-enable bit of the word is set, a one-cycle interrupt pulse is raised at that moment and a sticky done flag is set. The lowest bit of the word is forwarded unchanged to an external clock amplifier enable.

The largest legal exponent is the parameter `MAX_CODE`, which defaults to 20. Larger exponent values are clamped to it.

Top module: `clkdiv_startup_gate`

## Requirements
- R1: `amp_en` equals bit 0 of the most recent control write. It is 0 from reset until the first write.
- R2: Bits 7..1 of the control word set the divide ratio R. Field value 0 means R = 128. Any other value v means R = v. After a write on edge k, the divider's pulse occurs in cycles k+R, k+2R, and so on, counting cycle k+1 as the first cycle after the write edge.
- R3: Bits 12..8 hold the exponent N. `sys_run` rises in cycle k + R·2^N + 1 and then stays high until the next write.
- R4: An exponent above `MAX_CODE` behaves exactly like `MAX_CODE`.
- R5: A write clears `sys_run` and `done_flag` from the next cycle on. It also restarts the divider phase and the startup count, whatever state they were in.
- R6: When bit 13 is 1, `start_irq` is high for exactly the single cycle in which `sys_run` first rises. `done_flag` rises in that same cycle and stays high until the next write.
- R7: When bit 13 is 0, `start_irq` never pulses and `done_flag` stays 0. `sys_run` is still released on time.
- R8: After reset and before any write, `sys_run`, `sys_ce`, `start_irq` and `done_flag` are all 0.
- R9: `sys_ce` is high exactly in the cycles where `sys_run` is high and the divider pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 16 | Control word |
| sys_ce | output | 1 | Divided system clock enable, gated by startup |
| sys_run | output | 1 | System clock released (level) |
| start_irq | output | 1 | One-cycle startup interrupt |
| done_flag | output | 1 | Sticky startup-done status |
| amp_en | output | 1 | Clock amplifier enable, forwarded from bit 0 |

## Verification
The bench builds the block with `MAX_CODE` set to 4. This keeps every release interval short, at most 128·16 master cycles. It also makes the clamp reachable: exponent codes 5 to 31 all fold onto 4.

With that setting the bench can run several sweeps to completion:
- every divide field value, with the done enable alternating;
- every one of the 32 exponent codes;
- a grid of small ratios against all exponents.

Each case starts with a write that lands on top of the previous case's state. As a result, every case also exercises the restart behaviour.

// File: rtl/cdsg_pkg.sv
package cdsg_pkg;

  // Control word layout (fixed: fields are decoded by position)
  localparam int unsigned WORD_W     = 16;
  localparam int unsigned AMP_BIT    = 0;
  localparam int unsigned DIV_LO     = 1;
  localparam int unsigned DIV_W      = 7;
  localparam int unsigned EXP_LO     = DIV_LO + DIV_W;
  localparam int unsigned EXP_W      = 5;
  localparam int unsigned DONE_BIT   = EXP_LO + EXP_W;
  localparam int unsigned RATIO_FULL = 1 << DIV_W;
  localparam int unsigned RATIO_W    = DIV_W + 1;

  typedef struct packed {
    logic             done_en;
    logic [EXP_W-1:0] exp_code;
    logic [DIV_W-1:0] div_field;
    logic             amp;
  } ctrl_word_t;

  // Divide ratio from field: zero selects the full ratio
  function automatic int unsigned ratio_from_field(input int unsigned field);
    return (field == 0) ? RATIO_FULL : field;
  endfunction

  // Clamp an exponent code to the largest legal one
  function automatic int unsigned clamp_exp(input int unsigned code,
                                            input int unsigned max_code);
    return (code > max_code) ? max_code : code;
  endfunction

  // Number of divider pulses to wait, minus one
  function automatic int unsigned pulses_minus_one(input int unsigned code);
    return (32'd1 << code) - 32'd1;
  endfunction

endpackage

// File: rtl/cdsg_ctrl_reg.sv
module cdsg_ctrl_reg
  import cdsg_pkg::*;
#(
  parameter int unsigned MAX_CODE = 20,
  localparam int unsigned CODE_W  = $clog2(MAX_CODE + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [WORD_W-1:0]   wr_data,
  output logic                restart,
  output logic                done_en,
  output logic                amp_en,
  output logic [RATIO_W-1:0]  ratio_eff,
  output logic [CODE_W-1:0]   code_eff
);

  ctrl_word_t word_q;
  ctrl_word_t word_in;

  assign word_in = ctrl_word_t'(wr_data[DONE_BIT:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (wr_en) begin
      word_q <= word_in;
    end
  end

  // Restart is the write strobe itself: the divider and counter reload on
  // the same edge that the new configuration is captured.
  assign restart   = wr_en;
  assign done_en   = word_q.done_en;
  assign amp_en    = word_q.amp;
  assign ratio_eff = RATIO_W'(ratio_from_field(int'(word_q.div_field)));
  assign code_eff  = CODE_W'(clamp_exp(int'(word_q.exp_code), MAX_CODE));

endmodule

// File: rtl/cdsg_divider.sv
module cdsg_divider
  import cdsg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic [RATIO_W-1:0] ratio,
  output logic               tick
);

  logic [RATIO_W-1:0] phase_q;
  logic               at_end;

  assign at_end = (phase_q == ratio - RATIO_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (restart || at_end) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + RATIO_W'(1);
    end
  end

  // A write cycle never produces a pulse; phase is being reloaded
  assign tick = at_end && !restart;

endmodule

// File: rtl/cdsg_startup.sv
module cdsg_startup
  import cdsg_pkg::*;
#(
  parameter int unsigned MAX_CODE = 20,
  localparam int unsigned CODE_W  = $clog2(MAX_CODE + 1),
  localparam int unsigned CNT_W   = (MAX_CODE < 1) ? 1 : MAX_CODE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              tick,
  input  logic              done_en,
  input  logic [CODE_W-1:0] code,
  output logic              expire,
  output logic              released,
  output logic              irq,
  output logic              status
);

  typedef enum logic [1:0] { ST_IDLE, ST_COUNT, ST_DONE } st_t;

  st_t              st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_cnt;

  assign last_cnt = CNT_W'(pulses_minus_one(int'(code)));
  assign expire   = (st_q == ST_COUNT) && tick && (cnt_q == last_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else if (restart) begin
      st_q  <= ST_COUNT;
      cnt_q <= '0;
    end else if (expire) begin
      st_q  <= ST_DONE;
    end else if (st_q == ST_COUNT && tick) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      released <= 1'b0;
      irq      <= 1'b0;
      status   <= 1'b0;
    end else begin
      irq <= expire && done_en && !restart;
      if (restart) begin
        released <= 1'b0;
        status   <= 1'b0;
      end else if (expire) begin
        released <= 1'b1;
        status   <= done_en;
      end
    end
  end

endmodule

// File: rtl/clkdiv_startup_gate.sv
module clkdiv_startup_gate
  import cdsg_pkg::*;
#(
  parameter int unsigned MAX_CODE = 20,
  localparam int unsigned CODE_W  = $clog2(MAX_CODE + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic              sys_ce,
  output logic              sys_run,
  output logic              start_irq,
  output logic              done_flag,
  output logic              amp_en
);

  // Named internal events, visible to the bound checker
  logic               restart;
  logic               done_en;
  logic               div_tick;
  logic               expire;
  logic [RATIO_W-1:0] ratio_eff;
  logic [CODE_W-1:0]  code_eff;

  cdsg_ctrl_reg #(.MAX_CODE(MAX_CODE)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .restart   (restart),
    .done_en   (done_en),
    .amp_en    (amp_en),
    .ratio_eff (ratio_eff),
    .code_eff  (code_eff)
  );

  cdsg_divider u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .ratio   (ratio_eff),
    .tick    (div_tick)
  );

  cdsg_startup #(.MAX_CODE(MAX_CODE)) u_start (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart),
    .tick     (div_tick),
    .done_en  (done_en),
    .code     (code_eff),
    .expire   (expire),
    .released (sys_run),
    .irq      (start_irq),
    .status   (done_flag)
  );

  assign sys_ce = sys_run && div_tick;

endmodule

// File: rtl/clkdiv_startup_gate_chk.sv
module clkdiv_startup_gate_chk
  import cdsg_pkg::*;
#(
  parameter int unsigned MAX_CODE = 20,
  localparam int unsigned CODE_W  = $clog2(MAX_CODE + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic               div_tick,
  input logic               expire,
  input logic [RATIO_W-1:0] ratio_eff,
  input logic [CODE_W-1:0]  code_eff,
  input logic               sys_ce,
  input logic               sys_run,
  input logic               start_irq,
  input logic               done_flag
);

  // Cycles since the last divider pulse or write, counted independently
  logic [RATIO_W:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                gap_q <= (RATIO_W+1)'(1);
    else if (wr_en || div_tick) gap_q <= (RATIO_W+1)'(1);
    else                       gap_q <= gap_q + (RATIO_W+1)'(1);
  end

  p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    div_tick |-> (gap_q == {1'b0, ratio_eff}));

  p_run_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_run && !wr_en) |=> sys_run);

  p_code_clamped_r4: assert property (@(posedge clk) disable iff (!rst_n)
    code_eff <= CODE_W'(MAX_CODE));

  p_write_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (!sys_run && !done_flag));

  p_irq_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start_irq |=> !start_irq);

  p_irq_at_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start_irq |-> ($rose(sys_run) && $rose(done_flag)));

  p_flag_from_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> start_irq);

  p_ce_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sys_ce |-> (sys_run && div_tick));

  p_release_after_expire_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !wr_en) |=> sys_run);

endmodule

bind clkdiv_startup_gate clkdiv_startup_gate_chk #(.MAX_CODE(MAX_CODE)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .div_tick  (div_tick),
  .expire    (expire),
  .ratio_eff (ratio_eff),
  .code_eff  (code_eff),
  .sys_ce    (sys_ce),
  .sys_run   (sys_run),
  .start_irq (start_irq),
  .done_flag (done_flag)
);

// File: tb/clkdiv_startup_gate_bench.sv
module clkdiv_startup_gate_bench;

  localparam int unsigned MAXC = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        sys_ce, sys_run, start_irq, done_flag, amp_en;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  clkdiv_startup_gate #(.MAX_CODE(MAXC)) u_clkdiv_startup_gate (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .sys_ce(sys_ce), .sys_run(sys_run), .start_irq(start_irq),
    .done_flag(done_flag), .amp_en(amp_en)
  );

  task automatic check(input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One write followed by a full observation window.
  task automatic run_case(input int div_f, input int code, input bit den,
                          input bit amp, input string tag);
    int r, e, rel, win;
    int bad_run, bad_ce, bad_irq, bad_flag;
    int first_run_a, first_ce_a, first_irq_a, first_flag_a;
    int first_run_e, first_ce_e, first_irq_e, first_flag_e;
    r   = (div_f == 0) ? 128 : div_f;
    e   = 1 << ((code > MAXC) ? MAXC : code);
    rel = r * e;               // run visible from cycle rel+1
    win = rel + 3 * r + 2;
    bad_run = 0; bad_ce = 0; bad_irq = 0; bad_flag = 0;
    first_run_a = 0; first_ce_a = 0; first_irq_a = 0; first_flag_a = 0;
    first_run_e = 0; first_ce_e = 0; first_irq_e = 0; first_flag_e = 0;
    @(negedge clk);
    wr_data = {2'b00, den, 5'(code), 7'(div_f), amp};
    wr_en   = 1'b1;
    @(posedge clk);
    #1 wr_en = 1'b0;
    for (int i = 1; i <= win; i++) begin
      bit xr, xc, xi, xf;
      @(negedge clk);
      xr = (i > rel);
      xc = xr && (i % r == 0);
      xi = den && (i == rel + 1);
      xf = den && xr;
      if (i == 1) begin
        check("R5", "run/flag cleared after write", {sys_run, done_flag}, 0);
      end
      if (sys_run != xr && bad_run++ == 0) begin first_run_a = sys_run; first_run_e = xr; end
      if (sys_ce != xc && bad_ce++ == 0) begin first_ce_a = sys_ce; first_ce_e = xc; end
      if (start_irq != xi && bad_irq++ == 0) begin first_irq_a = start_irq; first_irq_e = xi; end
      if (done_flag != xf && bad_flag++ == 0) begin first_flag_a = done_flag; first_flag_e = xf; end
    end
    check({"R3 ", tag}, $sformatf("sys_run r=%0d code=%0d bad=%0d", r, code, bad_run),
          first_run_a, first_run_e);
    check({"R2/R9 ", tag}, $sformatf("sys_ce r=%0d code=%0d bad=%0d", r, code, bad_ce),
          first_ce_a, first_ce_e);
    check(den ? "R6" : "R7", $sformatf("start_irq r=%0d code=%0d bad=%0d", r, code, bad_irq),
          first_irq_a, first_irq_e);
    check(den ? "R6" : "R7", $sformatf("done_flag r=%0d code=%0d bad=%0d", r, code, bad_flag),
          first_flag_a, first_flag_e);
    check("R1", "amp_en", amp_en, amp);
  endtask

  initial begin
    #1000000000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R8: idle after reset, including past one full default divide period
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (i == 0 || i == 299)
        check("R8", "outputs idle after reset",
              {sys_ce, sys_run, start_irq, done_flag, amp_en}, 0);
    end

    // R2: every divide field value, done enable alternating
    for (int d = 0; d < 128; d++)
      run_case(d, d % 2, d[0], d[1], "ratio sweep");

    // R3/R4: every exponent code, including the clamped ones
    for (int c = 0; c < 32; c++)
      run_case(3, c, 1'b1, c[0], (c > MAXC) ? "R4 clamp" : "exp sweep");

    // Grid of small ratios against legal exponents, both done settings
    for (int d = 1; d <= 5; d++)
      for (int c = 0; c <= MAXC; c++)
        run_case(d, c, (d + c) % 2 == 0, 1'b0, "grid");

    // R5: rewrite in the middle of a count, then a full case
    @(negedge clk);
    wr_data = {2'b00, 1'b1, 5'd4, 7'd5, 1'b1};
    wr_en = 1'b1;
    @(posedge clk);
    #1 wr_en = 1'b0;
    repeat (37) @(negedge clk);
    check("R5", "no release before end of interrupted count", sys_run, 0);
    run_case(2, 2, 1'b1, 1'b0, "R5 restart");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule